// File: doc/BRIEF.md
# Standby Clock-Stop and Wake Controller

This block puts a small 8-bit microcontroller into a low-power standby state and brings it back out. Software first arms wake-up by setting a wake-enable bit, then writes a stop-clock register. From that point the CPU clock is gated off, so the core, its RAM and its I/O outputs all stay frozen.

A free-running oscillator clock keeps running. While the CPU is stopped, the block watches one 8-bit input port. The moment the synchronized port value differs from the value it captured at the stop write, standby ends and the CPU clock restarts on a whole pulse.

A stop write made without a prior arm is ignored. The clock gate is a latch-based enable, so the CPU clock never carries a shortened pulse on stop or restart.

Top module: `standby_wake_ctrl`

## Requirements
- R1: Standby is entered only by a stop-clock write (address 1, data ignored) made while the wake-enable bit (address 0, data bit 0) holds 1. `standby` is never high while that bit is 0.
- R2: A stop-clock write while the wake-enable bit is 0 is ignored. `standby` stays 0 and `cpuClk` keeps pulsing on every oscillator cycle.
- R3: On an accepted stop write, the oscillator edge that samples the write still produces its `cpuClk` pulse, and `standby` is 1 after that edge. No further `cpuClk` pulse occurs while `standby` is 1.
- R4: `cpuClk` is high only while `oscClk` is high, and each of its pulses is a full oscillator high phase.
- R5: While in standby, a difference on any single bit of `wakePort` from the value captured at the stop write clears `standby`. With the default two-stage synchronizer, a change driven between edges is seen at the third following rising edge of `oscClk`.
- R6: Port changes made while running have no effect on `standby` or on `cpuClk`. The wake reference is the synchronized port value at the stop write, so earlier changes cause no wake.
- R7: The wake-enable bit stays 1 across a wake. A later stop write enters standby without re-arming.
- R8: Register writes presented while in standby are ignored. This covers both a wake-enable clear and a repeated stop write.
- R9: Asserting reset (`rstN` low) forces the running state with wake-up disarmed, even from standby. A stop write after reset is then ignored.
- R10: After `standby` clears, the first `cpuClk` pulse is the next rising edge of `oscClk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| oscClk | input | 1 | Free-running oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe, sampled on oscClk rising edge |
| wrAddr | input | ADDR_W (2) | Register select: 0 wake-enable, 1 stop-clock |
| wrData | input | DATA_W (8) | Write data; bit 0 is the wake-enable value |
| wakePort | input | PORT_W (8) | Asynchronous wake port |
| cpuClk | output | 1 | Gated CPU clock |
| standby | output | 1 | High while the CPU clock is stopped |

## Verification
The bench builds the block with its defaults: an 8-bit wake port, a two-stage synchronizer, a 2-bit address and 8-bit data. With those values the exact three-edge wake latency and the first restart pulse can be timed cycle by cycle. Every one of the eight port bits is used in turn as the sole wake source, so a comparator lane that is dropped or miswired is exposed. Pulse counts are taken across entry, hold and wake windows, which brings the gate's edge alignment within reach of the checks.

// File: rtl/stby_pkg.sv
package stby_pkg;

  localparam int ADDR_WAKE_EN = 0;
  localparam int ADDR_STOP    = 1;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_HALT = 1'b1
  } stbyState_e;

  // Strobes from control to datapath and clock gate
  typedef struct packed {
    logic captureRef;  // snapshot the synchronized port now
    logic gateOpen;    // CPU clock allowed
  } stbyStrobes_t;

endpackage

// File: rtl/stby_dpath.sv
module stby_dpath
  import stby_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              oscClk,
  input  logic              rstN,
  input  logic [PORT_W-1:0] wakePort,
  input  stbyStrobes_t      strobes,
  output logic [PORT_W-1:0] portSync,
  output logic [PORT_W-1:0] refVal,
  output logic              portChanged
);

  logic [PORT_W-1:0] stage [SYNC_STAGES];

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge oscClk or negedge rstN) begin
        if (!rstN) stage[i] <= '0;
        else       stage[i] <= wakePort;
      end
    end else begin : g_next
      always_ff @(posedge oscClk or negedge rstN) begin
        if (!rstN) stage[i] <= '0;
        else       stage[i] <= stage[i-1];
      end
    end
  end

  assign portSync = stage[SYNC_STAGES-1];

  always_ff @(posedge oscClk or negedge rstN) begin
    if (!rstN)                   refVal <= '0;
    else if (strobes.captureRef) refVal <= portSync;
  end

  assign portChanged = |(portSync ^ refVal);

endmodule

// File: rtl/stby_ctrl.sv
module stby_ctrl
  import stby_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              oscClk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              portChanged,
  output stbyStrobes_t      strobes,
  output logic              standby,
  output logic              wakeEnQ
);

  localparam logic [ADDR_W-1:0] WakeSel = ADDR_W'(ADDR_WAKE_EN);
  localparam logic [ADDR_W-1:0] StopSel = ADDR_W'(ADDR_STOP);

  stbyState_e state, stateNxt;
  logic writeOk, armHit, stopHit, enterHit;

  // The core is frozen in standby, so nothing it presents is taken
  assign writeOk  = wrEn && (state == ST_RUN);
  assign armHit   = writeOk && (wrAddr == WakeSel);
  assign stopHit  = writeOk && (wrAddr == StopSel);
  assign enterHit = stopHit && wakeEnQ;

  always_ff @(posedge oscClk or negedge rstN) begin
    if (!rstN)       wakeEnQ <= 1'b0;
    else if (armHit) wakeEnQ <= wrData[0];
  end

  always_comb begin
    stateNxt = state;
    case (state)
      ST_RUN:  if (enterHit)    stateNxt = ST_HALT;
      ST_HALT: if (portChanged) stateNxt = ST_RUN;
      default: stateNxt = ST_RUN;
    endcase
  end

  always_ff @(posedge oscClk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNxt;
  end

  assign standby            = (state == ST_HALT);
  assign strobes.captureRef = enterHit;
  assign strobes.gateOpen   = (state == ST_RUN);

endmodule

// File: rtl/stby_clkgate.sv
module stby_clkgate (
  input  logic oscClk,
  input  logic gateOpen,
  output logic cpuClk
);

  logic enLat;

  // Transparent in the low phase only: enable is frozen while oscClk is high
  always_latch begin
    if (!oscClk) enLat = gateOpen;
  end

  assign cpuClk = oscClk & enLat;

endmodule

// File: rtl/standby_wake_ctrl.sv
module standby_wake_ctrl
  import stby_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 2,
  parameter int DATA_W      = 8
) (
  input  logic              oscClk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [PORT_W-1:0] wakePort,
  output logic              cpuClk,
  output logic              standby
);

  stbyStrobes_t      strobes;
  logic              portChanged;
  logic              wakeEnQ;
  logic [PORT_W-1:0] portSync;
  logic [PORT_W-1:0] refVal;

  stby_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctrl_i (
    .oscClk(oscClk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .portChanged(portChanged), .strobes(strobes),
    .standby(standby), .wakeEnQ(wakeEnQ)
  );

  stby_dpath #(.PORT_W(PORT_W), .SYNC_STAGES(SYNC_STAGES)) dpath_i (
    .oscClk(oscClk), .rstN(rstN), .wakePort(wakePort), .strobes(strobes),
    .portSync(portSync), .refVal(refVal), .portChanged(portChanged)
  );

  stby_clkgate gate_i (
    .oscClk(oscClk), .gateOpen(strobes.gateOpen), .cpuClk(cpuClk)
  );

endmodule

// File: rtl/stby_checker.sv
module stby_checker #(
  parameter int PORT_W = 8,
  parameter int ADDR_W = 2
) (
  input logic              oscClk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              standby,
  input logic              wakeEnQ,
  input logic [PORT_W-1:0] portSync,
  input logic [PORT_W-1:0] refVal
);

  localparam logic [ADDR_W-1:0] StopSel = ADDR_W'(1);

  // R1
  arm_needed_chk: assert property (@(posedge oscClk) disable iff (!rstN)
    standby |-> wakeEnQ);

  // R2
  unarmed_stop_chk: assert property (@(posedge oscClk) disable iff (!rstN)
    (wrEn && wrAddr == StopSel && !wakeEnQ && !standby) |=> !standby);

  // R3
  entry_cause_chk: assert property (@(posedge oscClk) disable iff (!rstN)
    $rose(standby) |-> $past(wrEn && wrAddr == StopSel));

  // R5
  wake_cause_chk: assert property (@(posedge oscClk) disable iff (!rstN)
    $fell(standby) |-> $past(portSync != refVal));

  // R8
  frozen_regs_chk: assert property (@(posedge oscClk) disable iff (!rstN)
    (standby && $past(standby)) |-> ($stable(refVal) && $stable(wakeEnQ)));

endmodule

bind standby_wake_ctrl stby_checker #(.PORT_W(PORT_W), .ADDR_W(ADDR_W)) chk_i (
  .oscClk(oscClk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
  .standby(standby), .wakeEnQ(wakeEnQ), .portSync(portSync), .refVal(refVal)
);

// File: tb/standby_wake_ctrl_tb.sv
module standby_wake_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int PORT_W = 8;

  logic              oscClk = 1'b0;
  logic              rstN   = 1'b0;
  logic              wrEn   = 1'b0;
  logic [1:0]        wrAddr = '0;
  logic [7:0]        wrData = '0;
  logic [PORT_W-1:0] wakePort = 8'hA5;
  logic              cpuClk, standby;

  standby_wake_ctrl dut_i (
    .oscClk(oscClk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .wakePort(wakePort), .cpuClk(cpuClk), .standby(standby)
  );

  always #(CLK_PERIOD/2) oscClk = ~oscClk;

  typedef struct {
    string tag;
    bit    stb;
    bit    chkPulse;
    int    pulses;
    int    base;
  } expItem_t;

  expItem_t q[$];
  int total = 0, bad = 0;
  int pulseCnt = 0, glitchCnt = 0;
  bit done = 0;

  always @(posedge cpuClk) begin
    pulseCnt++;
    if (!oscClk) glitchCnt++;
  end

  // Monitor: pops expected items just after the falling edge
  initial begin
    forever begin
      @(negedge oscClk);
      #1;
      if (rstN && cpuClk) glitchCnt++;
      while (q.size() > 0) begin
        expItem_t it;
        it = q.pop_front();
        total++;
        if (standby !== it.stb) begin
          bad++;
          $display("FAIL %s: standby=%0b expected %0b", it.tag, standby, it.stb);
        end
        if (it.chkPulse) begin
          total++;
          if (pulseCnt - it.base != it.pulses) begin
            bad++;
            $display("FAIL %s: cpuClk pulses=%0d expected %0d",
                     it.tag, pulseCnt - it.base, it.pulses);
          end
        end
      end
    end
  end

  task automatic expect_(string tag, bit stb, bit chkP = 0, int pulses = 0, int base = 0);
    expItem_t it;
    it.tag = tag; it.stb = stb; it.chkPulse = chkP; it.pulses = pulses; it.base = base;
    q.push_back(it);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge oscClk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge oscClk);
    wrAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge oscClk);
    wrEn = 1'b0;
  endtask

  task automatic flipBit(int b, bit timed);
    int base;
    @(negedge oscClk);
    wakePort[b] = ~wakePort[b];
    base = pulseCnt;
    tick(2);
    if (timed) expect_("R5 still stopped during sync", 1'b1, 1'b1, 0, base);
    tick(1);
    expect_($sformatf("R5 wake by bit %0d", b), 1'b0, timed, 0, base);
    tick(1);
    if (timed) expect_("R10 first pulse after wake", 1'b0, 1'b1, 1, base);
  endtask

  initial begin
    int base;
    tick(3);
    rstN = 1'b1;
    tick(3);
    expect_("R9 reset state running", 1'b0);
    base = pulseCnt; tick(4);
    expect_("R9 clock runs after reset", 1'b0, 1'b1, 4, base);

    // R2: stop without arm
    wr(2'd1, 8'h00);
    expect_("R2 unarmed stop ignored", 1'b0);
    base = pulseCnt; tick(5);
    expect_("R2 clock keeps running", 1'b0, 1'b1, 5, base);

    // R1 / R3: arm then stop
    wr(2'd0, 8'h01);
    base = pulseCnt;
    wr(2'd1, 8'h00);
    expect_("R1 R3 armed stop enters standby", 1'b1, 1'b1, 2, base);
    base = pulseCnt; tick(10);
    expect_("R3 no pulses in standby", 1'b1, 1'b1, 0, base);

    // R8: writes during standby ignored
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    expect_("R8 writes in standby ignored", 1'b1);

    // R5 / R10: timed wake on bit 3
    flipBit(3, 1'b1);

    // R7 / R8: enable persisted, earlier clear was dropped
    wr(2'd1, 8'h00);
    expect_("R7 R8 re-stop without re-arm", 1'b1);

    // R5: each bit alone wakes
    for (int b = 0; b < PORT_W; b++) begin
      flipBit(b, 1'b0);
      wr(2'd1, 8'h00);
      expect_("R5 re-enter standby", 1'b1);
    end
    flipBit(0, 1'b0);

    // R6: running port change has no effect; reference taken at stop
    @(negedge oscClk);
    wakePort = 8'h3C;
    base = pulseCnt; tick(4);
    expect_("R6 port change while running", 1'b0, 1'b1, 4, base);
    wr(2'd1, 8'h00);
    base = pulseCnt; tick(6);
    expect_("R6 no wake from pre-stop change", 1'b1, 1'b1, 0, base);
    flipBit(7, 1'b0);

    // R2: disarm then stop
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    expect_("R2 disarmed stop ignored", 1'b0);

    // R9: reset from standby
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h00);
    expect_("R9 standby before reset", 1'b1);
    @(negedge oscClk); rstN = 1'b0;
    @(negedge oscClk); rstN = 1'b1;
    expect_("R9 reset leaves standby", 1'b0);
    tick(3);
    wr(2'd1, 8'h00);
    expect_("R9 reset disarms wake", 1'b0);

    tick(2);
    wait (q.size() == 0);
    tick(1);
    total++;
    if (glitchCnt != 0) begin
      bad++;
      $display("FAIL R4: short cpuClk pulses=%0d expected 0", glitchCnt);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule